// File: doc/BRIEF.md
# Emergency Brake Output Override

This block stands between a PWM generator and its output pin. When the emergency-brake event picked by a channel select becomes active, the block latches a brake condition. While the brake is latched it replaces the PWM level with an override state chosen by a 2-bit code. That state can pass the PWM level through unchanged, tri-state the pin, drive it low or drive it high. The latched brake condition is also brought out as a status bit.

Leaving the brake state is controlled by a release-mode code. The brake can drop as soon as the event is seen inactive. It can also be held until the counter's next overflow pulse, its next underflow pulse, or whichever of the two comes first, provided the event is inactive in that same cycle. The pin level, the output enable and the status are all registered. They change on the same clock edge that first samples the active event, so the override takes effect within one clock.

Top module: `brk_override`

## Requirements
- R1: While the synchronous active-high reset is asserted, and on the first sample after it, the outputs read brake status 0, pin level 0 and output enable 1.
- R2: The select value k (00 to 11) makes `evt_i[k]` the only brake source. Activity on the other three event lines leaves status, pin and enable exactly as they would be with those lines low.
- R3: At the clock edge where the selected event is sampled high, brake status becomes 1 and the override is applied at that same edge.
- R4: While the brake is latched, the override code decides the outputs as follows. 00 gives the pin the PWM level from the previous cycle with enable 1. 01 gives enable 0 and pin 0. 10 gives pin 0 with enable 1. 11 gives pin 1 with enable 1.
- R5: While the brake is not latched, the pin equals the PWM level sampled at the previous edge and the enable is 1.
- R6: Release code 00 clears the brake at the first edge where the selected event is sampled low.
- R7: Release code 01 clears the brake only at an edge where the overflow pulse is high and the selected event is low. An underflow pulse alone does not clear it.
- R8: Release code 10 clears the brake only at an edge where the underflow pulse is high and the selected event is low. An overflow pulse alone does not clear it.
- R9: Release code 11 clears the brake at an edge where either pulse is high and the selected event is low.
- R10: If the selected event is high at a release point, including one where the counter pulse coincides with the event, the brake stays latched.
- R11: Brake status follows the latched state, not the raw event. It stays 1 while the event is low and a release point is still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| evt_i | input | NUM_EVT | Brake event lines, active high |
| evt_sel_i | input | SEL_W | Index of the brake event line in use |
| ovr_mode_i | input | 2 | Override state: 00 none, 01 high impedance, 10 low, 11 high |
| rel_mode_i | input | 2 | Release: 00 immediate, 01 overflow, 10 underflow, 11 either |
| pwm_i | input | 1 | Normal PWM level |
| cnt_ovf_i | input | 1 | Counter overflow pulse |
| cnt_udf_i | input | 1 | Counter underflow pulse |
| pin_o | output | 1 | Final pin level |
| pin_oe_o | output | 1 | Pin output enable (0 means tri-state) |
| brk_active_o | output | 1 | Latched brake status |

## Verification
The properties are checked on every cycle. They cover the following: an active selected event always yields a latched brake on the next edge, and immediate release drops the brake. Held release modes keep the brake when their counter pulse is absent. The high-impedance code deasserts the enable, and the enable is never low without a latched brake. The bench scenarios are needed for the behaviour that properties do not capture well. That includes the exact pin levels for each override code, and ignoring unselected event lines under the present select. It also includes the full release ordering when events reassert just before, or on the same edge as, a counter pulse. A random phase with a fixed seed compares all three outputs against a bench model on every cycle.

// File: rtl/brk_pkg.sv
package brk_pkg;
  typedef enum logic [1:0] {
    OVR_NONE = 2'b00,
    OVR_HIZ  = 2'b01,
    OVR_LOW  = 2'b10,
    OVR_HIGH = 2'b11
  } ovr_e;

  typedef enum logic [1:0] {
    REL_NOW = 2'b00,
    REL_OVF = 2'b01,
    REL_UDF = 2'b10,
    REL_ANY = 2'b11
  } rel_e;
endpackage

// File: rtl/brk_evt_sel.sv
module brk_evt_sel #(
  parameter int NUM_EVT = 4,
  parameter int SEL_W   = 2
) (
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               evt_o
);
  logic [NUM_EVT-1:0] hit;

  // One-hot gate per line; this scales to any line count without an index range check.
  for (genvar k = 0; k < NUM_EVT; k++) begin : g_hit
    assign hit[k] = evt_i[k] && (sel_i == SEL_W'(k));
  end

  assign evt_o = |hit;
endmodule

// File: rtl/brk_latch.sv
module brk_latch
  import brk_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       evt_i,
  input  logic [1:0] rel_mode_i,
  input  logic       ovf_i,
  input  logic       udf_i,
  output logic       brk_next_o,
  output logic       brk_q_o
);
  logic rel_point;

  always_comb begin
    unique case (rel_e'(rel_mode_i))
      REL_NOW: rel_point = 1'b1;
      REL_OVF: rel_point = ovf_i;
      REL_UDF: rel_point = udf_i;
      default: rel_point = ovf_i | udf_i;
    endcase
  end

  // Event wins over any release point; a pending release waits for its pulse.
  assign brk_next_o = evt_i | (brk_q_o & ~rel_point);

  always_ff @(posedge clk_i) begin
    if (rst_i) brk_q_o <= 1'b0;
    else       brk_q_o <= brk_next_o;
  end
endmodule

// File: rtl/brk_pin_drive.sv
module brk_pin_drive
  import brk_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       brk_i,
  input  logic [1:0] ovr_mode_i,
  input  logic       pwm_i,
  output logic       pin_o,
  output logic       oe_o
);
  logic pin_d, oe_d;

  always_comb begin
    pin_d = pwm_i;
    oe_d  = 1'b1;
    if (brk_i) begin
      unique case (ovr_e'(ovr_mode_i))
        OVR_NONE: begin pin_d = pwm_i; oe_d = 1'b1; end
        OVR_HIZ:  begin pin_d = 1'b0;  oe_d = 1'b0; end
        OVR_LOW:  begin pin_d = 1'b0;  oe_d = 1'b1; end
        default:  begin pin_d = 1'b1;  oe_d = 1'b1; end
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pin_o <= 1'b0;
      oe_o  <= 1'b1;
    end else begin
      pin_o <= pin_d;
      oe_o  <= oe_d;
    end
  end
endmodule

// File: rtl/brk_override.sv
module brk_override #(
  parameter int NUM_EVT = 4,
  parameter int SEL_W   = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [SEL_W-1:0]   evt_sel_i,
  input  logic [1:0]         ovr_mode_i,
  input  logic [1:0]         rel_mode_i,
  input  logic               pwm_i,
  input  logic               cnt_ovf_i,
  input  logic               cnt_udf_i,
  output logic               pin_o,
  output logic               pin_oe_o,
  output logic               brk_active_o
);
  logic evt_sel;
  logic brk_next;

  brk_evt_sel #(.NUM_EVT(NUM_EVT), .SEL_W(SEL_W)) u_sel (
    .evt_i (evt_i),
    .sel_i (evt_sel_i),
    .evt_o (evt_sel)
  );

  brk_latch u_latch (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .evt_i      (evt_sel),
    .rel_mode_i (rel_mode_i),
    .ovf_i      (cnt_ovf_i),
    .udf_i      (cnt_udf_i),
    .brk_next_o (brk_next),
    .brk_q_o    (brk_active_o)
  );

  // Driven from the next brake state so the override lands on the latching edge.
  brk_pin_drive u_drv (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .brk_i      (brk_next),
    .ovr_mode_i (ovr_mode_i),
    .pwm_i      (pwm_i),
    .pin_o      (pin_o),
    .oe_o       (pin_oe_o)
  );
endmodule

// File: rtl/brk_override_chk.sv
module brk_override_chk #(
  parameter int NUM_EVT = 4,
  parameter int SEL_W   = 2
) (
  input logic               clk_i,
  input logic               rst_i,
  input logic [NUM_EVT-1:0] evt_i,
  input logic [SEL_W-1:0]   evt_sel_i,
  input logic [1:0]         ovr_mode_i,
  input logic [1:0]         rel_mode_i,
  input logic               pwm_i,
  input logic               cnt_ovf_i,
  input logic               cnt_udf_i,
  input logic               pin_o,
  input logic               pin_oe_o,
  input logic               brk_active_o
);
  logic ev;
  assign ev = evt_i[evt_sel_i];

  p_set_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    ev |=> brk_active_o);

  p_hiz_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (ev && ovr_mode_i == 2'b01) |=> !pin_oe_o);

  p_oe_needs_brake_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    !pin_oe_o |-> brk_active_o);

  p_idle_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (!brk_active_o && !ev) |=> (pin_oe_o && !brk_active_o && pin_o == $past(pwm_i)));

  p_release_now_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (brk_active_o && !ev && rel_mode_i == 2'b00) |=> !brk_active_o);

  p_hold_ovf_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (brk_active_o && rel_mode_i == 2'b01 && !cnt_ovf_i) |=> brk_active_o);

  p_hold_udf_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (brk_active_o && rel_mode_i == 2'b10 && !cnt_udf_i) |=> brk_active_o);

  p_release_any_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    (brk_active_o && !ev && rel_mode_i == 2'b11 && (cnt_ovf_i || cnt_udf_i)) |=> !brk_active_o);
endmodule

bind brk_override brk_override_chk #(.NUM_EVT(NUM_EVT), .SEL_W(SEL_W)) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .evt_i(evt_i), .evt_sel_i(evt_sel_i),
  .ovr_mode_i(ovr_mode_i), .rel_mode_i(rel_mode_i), .pwm_i(pwm_i),
  .cnt_ovf_i(cnt_ovf_i), .cnt_udf_i(cnt_udf_i), .pin_o(pin_o),
  .pin_oe_o(pin_oe_o), .brk_active_o(brk_active_o)
);

// File: tb/brk_override_tb.sv
`timescale 1ns/1ps
module brk_override_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] evt;
  logic [1:0] sel, ovr, rel;
  logic       pwm, ovf, udf;
  logic       pin, oe, brk;

  int checks = 0;
  int errors = 0;
  logic m_brk, m_pin, m_oe;

  always #2.5 clk = ~clk;

  brk_override u_dut (
    .clk_i(clk), .rst_i(rst), .evt_i(evt), .evt_sel_i(sel),
    .ovr_mode_i(ovr), .rel_mode_i(rel), .pwm_i(pwm),
    .cnt_ovf_i(ovf), .cnt_udf_i(udf),
    .pin_o(pin), .pin_oe_o(oe), .brk_active_o(brk)
  );

  function automatic logic next_brk(logic cur, logic e, logic [1:0] r, logic o, logic u);
    logic rp;
    case (r)
      2'b00: rp = 1'b1;
      2'b01: rp = o;
      2'b10: rp = u;
      default: rp = o | u;
    endcase
    return e | (cur & ~rp);
  endfunction

  task automatic model_edge();
    logic nb;
    nb = next_brk(m_brk, evt[sel], rel, ovf, udf);
    m_brk = nb;
    m_pin = pwm; m_oe = 1'b1;
    if (nb) begin
      case (ovr)
        2'b01: begin m_pin = 1'b0; m_oe = 1'b0; end
        2'b10: begin m_pin = 1'b0; m_oe = 1'b1; end
        2'b11: begin m_pin = 1'b1; m_oe = 1'b1; end
        default: ;
      endcase
    end
  endtask

  task automatic compare(string tag);
    checks++;
    if (brk !== m_brk || pin !== m_pin || oe !== m_oe) begin
      errors++;
      $display("FAIL %s: actual brk=%b pin=%b oe=%b expected brk=%b pin=%b oe=%b",
               tag, brk, pin, oe, m_brk, m_pin, m_oe);
    end
  endtask

  // Inputs are changed at the falling edge; outputs are compared at the next falling edge.
  task automatic step(logic [3:0] e, logic p, logic o, logic u, string tag);
    evt = e; pwm = p; ovf = o; udf = u;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic cfg(logic [1:0] s, logic [1:0] ov, logic [1:0] rl);
    sel = s; ovr = ov; rel = rl;
  endtask

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250611));
    rst = 1'b1; evt = '0; sel = '0; ovr = '0; rel = '0; pwm = 0; ovf = 0; udf = 0;
    m_brk = 0; m_pin = 0; m_oe = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1 reset state");
    evt = 4'hF;
    @(negedge clk);
    compare("R1 reset holds with events");
    evt = '0;
    @(negedge clk);
    rst = 1'b0;
    step(4'h0, 1'b1, 0, 0, "R1 first sample after reset");

    // R5: idle pass-through
    cfg(2'd0, 2'b11, 2'b00);
    step(4'h0, 1'b1, 0, 0, "R5 idle pwm high");
    step(4'h0, 1'b0, 0, 0, "R5 idle pwm low");

    // R2: unselected lines ignored
    cfg(2'd2, 2'b11, 2'b00);
    step(4'b1011, 1'b0, 0, 0, "R2 unselected lines ignored");
    step(4'b0100, 1'b0, 0, 0, "R2 selected line 2 braking");
    step(4'b0000, 1'b0, 0, 0, "R6 immediate release");

    // R3/R4 each override code
    for (int c = 0; c < 4; c++) begin
      cfg(2'd1, 2'(c), 2'b00);
      step(4'b0010, 1'b1, 0, 0, "R3 R4 override applied on latching edge");
      step(4'b0010, 1'b0, 0, 0, "R4 override held");
      step(4'b0000, 1'b1, 0, 0, "R6 release code 00");
    end

    // R7 overflow release, udf ignored, R11 status held
    cfg(2'd3, 2'b10, 2'b01);
    step(4'b1000, 1'b1, 0, 0, "R7 latch");
    step(4'b0000, 1'b1, 0, 0, "R11 status held with event low");
    step(4'b0000, 1'b1, 0, 1, "R7 underflow does not release");
    step(4'b1000, 1'b1, 1, 0, "R10 overflow with event high keeps brake");
    step(4'b0000, 1'b1, 1, 0, "R7 overflow releases");

    // R8 underflow release
    cfg(2'd0, 2'b01, 2'b10);
    step(4'b0001, 1'b1, 0, 0, "R8 latch hiz");
    step(4'b0000, 1'b1, 1, 0, "R8 overflow does not release");
    step(4'b0001, 1'b1, 0, 0, "R10 reassert before underflow");
    step(4'b0000, 1'b1, 0, 1, "R8 underflow releases");

    // R9 either
    cfg(2'd1, 2'b11, 2'b11);
    step(4'b0010, 1'b0, 0, 0, "R9 latch");
    step(4'b0000, 1'b0, 0, 0, "R9 held without pulse");
    step(4'b0000, 1'b0, 0, 1, "R9 underflow releases");
    step(4'b0010, 1'b0, 0, 0, "R9 relatch");
    step(4'b0000, 1'b0, 1, 0, "R9 overflow releases");

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] e;
      if (i % 64 == 0) cfg(2'($urandom), 2'($urandom), 2'($urandom));
      e = ($urandom % 6 == 0) ? 4'($urandom) : 4'h0;
      step(e, 1'($urandom), ($urandom % 8 == 0), ($urandom % 8 == 0),
           "R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule